// File: doc/BRIEF.md
# Twin PWM DAC Core with Interface Auto-Detect

This block keeps two 6-bit output codes and turns each into a pulse-width-modulated digital output. Both channels share one free-running frame counter that advances on a clock-enable tick. A frame is 64 ticks long. Each output is high for as many ticks of the frame as its code value. A code change takes effect only at a frame boundary, so no frame ever shows a mix of old and new widths.

The way the codes are adjusted is chosen once, while reset is held. The block looks at a three-state reading of each of the two adjustment pins. If both pins float, it uses step mode: up and down requests move a code and stop at the ends of the range. Otherwise it uses count mode: increment strobes advance a code and roll over from the top value to zero. In step mode the block also tells the pin logic to keep its pull network in place. An active-low sleep input turns both outputs off (enables low) and freezes the codes. When sleep is released, the outputs resume with the codes they had before.

Top module: `twin_pwm_dac`

## Requirements
- R1: The mode is taken from `pinState` while `rstN` is low. Each 2-bit field uses the encoding 00 low, 01 high, 10 floating; pin 0 is bits [1:0] and pin 1 is bits [3:2]. If both fields read 10, the block uses step mode. Any other combination selects count mode.
- R2: Once reset is released, the mode does not change, whatever `pinState` does, until the next reset.
- R3: `pullKeep` is 1 in step mode and 0 in count mode.
- R4: After reset, both codes equal 32, which gives 32 high ticks per 64-tick frame.
- R5: In count mode, each clock cycle with `incStb[c]` high adds one to code c. Adding one to 63 gives 0.
- R6: In step mode, `upReq[c]` adds one but stops at 63, and `dnReq[c]` subtracts one but stops at 0. When both are high in the same cycle, the code does not change.
- R7: The other mode's inputs have no effect: in count mode `upReq` and `dnReq` are ignored, and in step mode `incStb` is ignored.
- R8: While running, `pwmOut[c]` is high exactly when the frame count is below code c. Code 0 gives no high ticks, and code 63 gives 63 high ticks out of 64.
- R9: The frame counter moves forward only on a cycle with `tick` high. With `tick` low, the outputs hold their level.
- R10: A new code goes into effect on the first tick after the frame count wraps from 63 to 0. The frame that is running when the change is requested finishes with the old width.
- R11: While `shdnN` is low, `pwmOe` and `pwmOut` are all 0 and all step and increment requests are ignored. When `shdnN` rises, the frame restarts at count 0 with the codes that were held, not 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset; mode is sampled while low |
| pinState | input | 4 | Three-state reading of the two adjustment pins, 2 bits each |
| tick | input | 1 | Clock enable for the frame counter |
| shdnN | input | 1 | Active-low sleep |
| incStb | input | 2 | Count-mode increment strobes, one per channel |
| upReq | input | 2 | Step-mode up requests, one per channel |
| dnReq | input | 2 | Step-mode down requests, one per channel |
| pwmOut | output | 2 | PWM outputs |
| pwmOe | output | 2 | Output enables, low means high impedance |
| pullKeep | output | 1 | 1 keeps the pin pull network connected |

## Verification
A wrong mode latch is visible on `pullKeep` in the first cycle after reset. It also shows up as wrap-versus-saturate behaviour at the first step past an end of the range. A wrong held code or applied code changes the count of high output ticks, so any 128-tick window that starts one frame after the last request shows the error. The bench knows the frame phase because a sleep release restarts the frame at zero. That lets it catch a code that is applied in the middle of a frame: the frame in which the request arrives would then show the wrong high count.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int CHANNELS = 2;
  localparam int CODE_W   = 6;
  localparam int PIN_W    = 2;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  localparam logic [PIN_W-1:0] PIN_LOW   = 2'b00;
  localparam logic [PIN_W-1:0] PIN_HIGH  = 2'b01;
  localparam logic [PIN_W-1:0] PIN_FLOAT = 2'b10;

  typedef logic [CHANNELS-1:0][CODE_W-1:0] chanCode_t;

  typedef struct packed {
    logic                run;
    logic                frameAdv;
    logic                wrapMode;
    logic [CHANNELS-1:0] stepUp;
    logic [CHANNELS-1:0] stepDown;
  } stepCmd_t;
endpackage

// File: rtl/twin_pwm_ctrl.sv
module twin_pwm_ctrl
  import twin_pwm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CHANNELS*PIN_W-1:0] pinState,
  input  logic                      tick,
  input  logic                      shdnN,
  input  logic [CHANNELS-1:0]       incStb,
  input  logic [CHANNELS-1:0]       upReq,
  input  logic [CHANNELS-1:0]       dnReq,
  output stepCmd_t                  cmd,
  output logic                      stepMode
);
  logic [CHANNELS-1:0] pinFloat;
  logic                allFloat;

  // Decode the three-state reading of each pin.
  for (genvar p = 0; p < CHANNELS; p++) begin : g_pin
    assign pinFloat[p] = (pinState[p*PIN_W +: PIN_W] == PIN_FLOAT);
  end
  assign allFloat = &pinFloat;

  // The mode follows the pins while reset is held, then stays frozen.
  always_ff @(posedge clk) begin
    if (!rstN) stepMode <= allFloat;
  end

  always_comb begin
    cmd.run      = shdnN;
    cmd.frameAdv = shdnN & tick;
    cmd.wrapMode = ~stepMode;
    if (stepMode) begin
      cmd.stepUp   = upReq & ~dnReq & {CHANNELS{shdnN}};
      cmd.stepDown = dnReq & ~upReq & {CHANNELS{shdnN}};
    end else begin
      cmd.stepUp   = incStb & {CHANNELS{shdnN}};
      cmd.stepDown = '0;
    end
  end
endmodule

// File: rtl/twin_pwm_datapath.sv
module twin_pwm_datapath
  import twin_pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stepCmd_t            cmd,
  output logic [CHANNELS-1:0] pwmOut,
  output logic [CHANNELS-1:0] pwmOe,
  output logic [CODE_W-1:0]   frameCnt,
  output chanCode_t           pendCode,
  output chanCode_t           activeCode
);
  logic frameEnd;

  // Shared frame counter; it is held at zero while asleep.
  always_ff @(posedge clk) begin
    if (!rstN || !cmd.run) frameCnt <= '0;
    else if (cmd.frameAdv) frameCnt <= frameCnt + 1'b1;
  end

  assign frameEnd = cmd.frameAdv && (frameCnt == CODE_MAX);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [CODE_W-1:0] pendQ;
    logic [CODE_W-1:0] actQ;
    logic              atTop;
    logic              atBottom;

    assign atTop    = (pendQ == CODE_MAX);
    assign atBottom = (pendQ == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= CODE_MID;
        actQ  <= CODE_MID;
      end else begin
        if (cmd.stepUp[c]) begin
          if (!atTop || cmd.wrapMode) pendQ <= pendQ + 1'b1;
        end else if (cmd.stepDown[c]) begin
          if (!atBottom) pendQ <= pendQ - 1'b1;
        end
        if (frameEnd || !cmd.run) actQ <= pendQ;
      end
    end

    assign pendCode[c]   = pendQ;
    assign activeCode[c] = actQ;
    assign pwmOut[c]     = cmd.run && (frameCnt < actQ);
    assign pwmOe[c]      = cmd.run;
  end
endmodule

// File: rtl/twin_pwm_dac.sv
module twin_pwm_dac
  import twin_pwm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CHANNELS*PIN_W-1:0] pinState,
  input  logic                      tick,
  input  logic                      shdnN,
  input  logic [CHANNELS-1:0]       incStb,
  input  logic [CHANNELS-1:0]       upReq,
  input  logic [CHANNELS-1:0]       dnReq,
  output logic [CHANNELS-1:0]       pwmOut,
  output logic [CHANNELS-1:0]       pwmOe,
  output logic                      pullKeep
);
  stepCmd_t          cmd;
  logic              stepMode;
  logic [CODE_W-1:0] frameCnt;
  chanCode_t         pendCode;
  chanCode_t         activeCode;

  twin_pwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinState(pinState), .tick(tick), .shdnN(shdnN),
    .incStb(incStb), .upReq(upReq), .dnReq(dnReq), .cmd(cmd), .stepMode(stepMode)
  );

  twin_pwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pwmOut(pwmOut), .pwmOe(pwmOe),
    .frameCnt(frameCnt), .pendCode(pendCode), .activeCode(activeCode)
  );

  assign pullKeep = stepMode;
endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk
  import twin_pwm_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                shdnN,
  input logic                tick,
  input logic                pullKeep,
  input logic [CHANNELS-1:0] pwmOut,
  input logic [CHANNELS-1:0] pwmOe,
  input logic [CODE_W-1:0]   frameCnt,
  input chanCode_t           pendCode,
  input chanCode_t           activeCode
);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(pullKeep));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |-> (pwmOe == '0 && pwmOut == '0));

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shdnN && !tick) |=> (frameCnt == $past(frameCnt)));

  // R10
  apply_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode != $past(activeCode)) |->
      (($past(frameCnt) == CODE_MAX && $past(tick)) || !$past(shdnN)));

  // R4
  mid_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (activeCode[0] == CODE_MID && activeCode[1] == CODE_MID));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_sat
    // R6
    step_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      pullKeep |-> !(($past(pendCode[c]) == CODE_MAX && pendCode[c] == '0) ||
                     ($past(pendCode[c]) == '0 && pendCode[c] == CODE_MAX)));
  end
endmodule

bind twin_pwm_dac twin_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .shdnN(shdnN), .tick(tick), .pullKeep(pullKeep),
  .pwmOut(pwmOut), .pwmOe(pwmOe), .frameCnt(frameCnt),
  .pendCode(pendCode), .activeCode(activeCode)
);

// File: tb/sim_twin_pwm_dac.sv
module sim_twin_pwm_dac;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // Count-mode table: {channel, pulse count, expected code}
  localparam int NVEC = 7;
  localparam logic [13:0] PULSE_TBL [NVEC] = '{
    {1'b0, 7'd1,  6'd33},
    {1'b1, 7'd5,  6'd37},
    {1'b0, 7'd30, 6'd63},
    {1'b0, 7'd1,  6'd0},
    {1'b1, 7'd26, 6'd63},
    {1'b1, 7'd2,  6'd1},
    {1'b0, 7'd10, 6'd10}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] pinState;
  logic       tick;
  logic       shdnN;
  logic [1:0] incStb, upReq, dnReq;
  logic [1:0] pwmOut, pwmOe;
  logic       pullKeep;

  int checks = 0;
  int errors = 0;

  twin_pwm_dac u0 (
    .clk(clk), .rstN(rstN), .pinState(pinState), .tick(tick), .shdnN(shdnN),
    .incStb(incStb), .upReq(upReq), .dnReq(dnReq),
    .pwmOut(pwmOut), .pwmOe(pwmOe), .pullKeep(pullKeep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [3:0] pins);
    @(negedge clk);
    rstN = 1'b0; pinState = pins;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // kind: 0 increment, 1 up, 2 down, 3 up and down together
  task automatic step(input int ch, input int kind, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (kind == 0) incStb[ch] = 1'b1;
      if (kind == 1 || kind == 3) upReq[ch] = 1'b1;
      if (kind == 2 || kind == 3) dnReq[ch] = 1'b1;
      @(negedge clk);
      incStb = '0; upReq = '0; dnReq = '0;
    end
  endtask

  // Wait one frame, then count high ticks over two whole frames.
  task automatic measure(input int ch, output int highs);
    repeat (64) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk); #1;
      highs += int'(pwmOut[ch]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, h0, h1, f0a, f1a, f1b, mism;
    logic [1:0] held;
    rstN = 1'b0; pinState = 4'b1010; tick = 1'b1; shdnN = 1'b1;
    incStb = '0; upReq = '0; dnReq = '0;

    // ---- step mode: both pins floating ----
    doReset(4'b1010);
    chk("R1 step mode from both floating", int'(pullKeep), 1);
    chk("R3 pulls kept in step mode", int'(pullKeep), 1);
    measure(0, h); chk("R4 ch0 midscale", h, 64);
    measure(1, h); chk("R4 ch1 midscale", h, 64);
    pinState = 4'b0000;
    repeat (5) @(negedge clk);
    chk("R2 mode held after pins change", int'(pullKeep), 1);
    step(0, 1, 40); measure(0, h); chk("R6 up stops at 63", h, 126);
    chk("R8 code 63 gives 63 of 64", h, 126);
    step(1, 2, 40); measure(1, h); chk("R6 down stops at 0", h, 0);
    chk("R8 code 0 gives no high ticks", h, 0);
    step(1, 3, 4); measure(1, h); chk("R6 up with down no change", h, 0);
    step(1, 0, 5); measure(1, h); chk("R7 incStb ignored in step mode", h, 0);
    step(0, 2, 5); measure(0, h); chk("R6 down from 63 by 5", h, 116);

    // ---- sleep: outputs off, codes held, requests ignored ----
    @(negedge clk); shdnN = 1'b0; #1;
    chk("R11 oe low in sleep", int'(pwmOe), 0);
    step(1, 1, 3);
    step(0, 2, 3);
    mism = 0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk); #1;
      if (pwmOut != 2'b00 || pwmOe != 2'b00) mism++;
    end
    chk("R11 outputs stay low in sleep", mism, 0);
    @(negedge clk); shdnN = 1'b1;
    f0a = 0; f1a = 0; f1b = 0;
    for (int i = 0; i < 128; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (i < 64) begin f0a += int'(pwmOut[0]); f1a += int'(pwmOut[1]); end
      else f1b += int'(pwmOut[1]);
      if (i == 10) upReq[1] = 1'b1;
      if (i == 11) upReq[1] = 1'b0;
    end
    chk("R11 oe high after wake", int'(pwmOe), 3);
    chk("R11 ch0 held code 58 after wake", f0a, 58);
    chk("R10 old width until wrap", f1a, 0);
    chk("R10 new width after wrap", f1b, 1);

    // ---- tick gating ----
    @(negedge clk); tick = 1'b0; #1;
    held = pwmOut; mism = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #1;
      if (pwmOut != held) mism++;
    end
    chk("R9 no advance without tick", mism, 0);
    @(negedge clk); tick = 1'b1;

    // ---- count mode: pin0 floating, pin1 high ----
    doReset(4'b0110);
    chk("R1 count mode with one pin driven", int'(pullKeep), 0);
    chk("R3 pulls removed in count mode", int'(pullKeep), 0);
    measure(1, h); chk("R4 ch1 midscale after reset", h, 64);
    for (int v = 0; v < NVEC; v++) begin
      step(int'(PULSE_TBL[v][13]), 0, int'(PULSE_TBL[v][12:6]));
      measure(int'(PULSE_TBL[v][13]), h);
      chk($sformatf("R5 pulse vector %0d", v), h, 2 * int'(PULSE_TBL[v][5:0]));
    end
    step(0, 2, 5); step(0, 1, 3);
    measure(0, h0); chk("R7 up/down ignored in count mode", h0, 20);
    measure(1, h1); chk("R5 ch1 unaffected by ch0", h1, 2);

    // ---- count mode: both pins low ----
    doReset(4'b0000);
    chk("R1 count mode with both low", int'(pullKeep), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule